// File: doc/BRIEF.md
# Quarter-Step Fractional Feedback Divider

This block divides the oscillator clock of a synthesizer loop by a programmable count and marks the end of each division period with a one-clock pulse. Two 18-bit division words are held at its inputs. A select line picks the one in use. An optional shift mode divides the chosen word by four, which makes the loop step four times coarser and lets it tune faster.

In shift mode the two low bits that the shift throws away are not lost when fractional mode is also on. They feed a two-bit accumulator that adds them once per period. Each carry out of the accumulator stretches that period by one clock. The average division is therefore the integer part plus 0, 1/4, 1/2 or 3/4. For example, the word 9113 gives 2278, 2278, 2278, 2279, which averages 2278.25.

Configuration is sampled only at a period boundary. The control sequence has two states. After reset the block is in `ST_START`. On the first clock it loads the first period and moves to `ST_COUNT` (transition *launch*). In `ST_COUNT` the counter steps down each clock (transition *tick*). When it reaches its last clock it reloads from the current configuration and raises the pulse, staying in `ST_COUNT` (transition *wrap*).

Top module: `qfrac_fb_div`

## Requirements
- R1: While `rst_n` is low, `div_pulse` is 0. After reset is released with a divisor D selected, the first pulse is seen D+1 clocks later: one clock loads the period, then D clocks count it.
- R2: `sel_b`=0 makes `n_word_a` the active word and `sel_b`=1 makes `n_word_b` the active word. The word that is not selected has no effect on the period.
- R3: With `shift_en_n`=1 (shift off), every period is exactly the full active word, in clocks.
- R4: With `shift_en_n`=0 and `frac_en_n`=1, every period is the active word shifted right by two bits. Bits [1:0] have no effect.
- R5: With `shift_en_n`=0 and `frac_en_n`=0, bits [1:0] of the active word are added to a modulo-4 accumulator once per period, and a carry lengthens that period by one clock. Any four consecutive periods therefore sum to the active word.
- R6: With `shift_en_n`=1, `frac_en_n` has no effect on the period.
- R7: A change to any word, select or mode input leaves the period in progress unchanged and applies from the next period onward.
- R8: `div_pulse` is high for exactly one clock per period and is never high on two consecutive clocks.
- R9: An effective divisor below 2, after any carry is added, is raised to 2.
- R10: The accumulator is held at zero while fractional mode is inactive, so the first fractional period after enabling starts from zero. With fraction 3 the periods are base, base+1, base+1, base+1. With fraction 2 they are base, base+1, base, base+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock that is being divided |
| rst_n | input | 1 | Asynchronous reset, active low |
| n_word_a | input | 18 | Division word A |
| n_word_b | input | 18 | Division word B |
| sel_b | input | 1 | 1 selects word B, 0 selects word A |
| shift_en_n | input | 1 | 0 enables the divide-by-four shift mode |
| frac_en_n | input | 1 | 0 enables quarter-step fractional mode (effective only with shift) |
| div_pulse | output | 1 | One-clock pulse at the end of each division period |

## Verification
The bench goes after the order of the dither: a fraction that starts from a stale accumulator value, or carries one period late, produces the wrong sequence of base and base+1 even when the four-period sum is right. It changes configuration in the middle of a period. A design that reloads immediately would cut the period in progress short or stretch it. It drives divisors of 0 and 1 in every mode. Without the floor of 2, these would give back-to-back pulses or a counter that wraps to its maximum. It also enables the fraction with shift off. A design that ignores the gating would then dither a divider that should be exact.

// File: rtl/qfd_pkg.sv
package qfd_pkg;
    // Bits dropped by the coarse shift; also the fraction width.
    localparam int SHIFT_W = 2;
    // Smallest period the counter can produce.
    localparam int MIN_DIV = 2;

    typedef enum logic [0:0] {
        ST_START = 1'b0,
        ST_COUNT = 1'b1
    } div_state_t;
endpackage

// File: rtl/qfd_word_sel.sv
module qfd_word_sel
    import qfd_pkg::*;
#(
    parameter int N_W = 18
) (
    input  logic [N_W-1:0]     word_a,
    input  logic [N_W-1:0]     word_b,
    input  logic               sel_b,
    input  logic               shift_en_n,
    input  logic               frac_en_n,
    output logic [N_W-1:0]     base,
    output logic [SHIFT_W-1:0] frac,
    output logic               frac_act
);
    localparam int NUM_WORDS = 2;

    logic [N_W-1:0] bank [NUM_WORDS];
    logic [N_W-1:0] active;
    logic           shift_on;

    assign bank[0] = word_a;
    assign bank[1] = word_b;

    assign active   = bank[sel_b];
    assign shift_on = ~shift_en_n;

    // Integer part: whole word, or the word with its low bits removed.
    assign base     = shift_on ? (active >> SHIFT_W) : active;
    assign frac     = active[SHIFT_W-1:0];
    assign frac_act = shift_on & ~frac_en_n;
endmodule

// File: rtl/qfd_frac_acc.sv
module qfd_frac_acc
    import qfd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic               frac_act,
    input  logic [SHIFT_W-1:0] frac,
    output logic               carry,
    output logic [SHIFT_W-1:0] acc_q
);
    logic [SHIFT_W:0] sum;

    assign sum   = {1'b0, acc_q} + {1'b0, frac};
    assign carry = frac_act & sum[SHIFT_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (load_en) begin
            acc_q <= frac_act ? sum[SHIFT_W-1:0] : '0;
        end
    end
endmodule

// File: rtl/qfd_divisor.sv
module qfd_divisor
    import qfd_pkg::*;
#(
    parameter int N_W   = 18,
    parameter int CNT_W = N_W + 1
) (
    input  logic [N_W-1:0]   base,
    input  logic             carry,
    output logic [CNT_W-1:0] div_val
);
    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_DIV);

    logic [CNT_W-1:0] raw;

    assign raw     = CNT_W'(base) + CNT_W'(carry);
    assign div_val = (raw < FLOOR) ? FLOOR : raw;
endmodule

// File: rtl/qfrac_fb_div.sv
module qfrac_fb_div
    import qfd_pkg::*;
#(
    parameter int N_W = 18
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N_W-1:0] n_word_a,
    input  logic [N_W-1:0] n_word_b,
    input  logic           sel_b,
    input  logic           shift_en_n,
    input  logic           frac_en_n,
    output logic           div_pulse
);
    localparam int               CNT_W = N_W + 1;
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(1);

    div_state_t         state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [N_W-1:0]     base;
    logic [SHIFT_W-1:0] frac;
    logic [SHIFT_W-1:0] acc_q;
    logic               frac_act;
    logic               carry;
    logic [CNT_W-1:0]   div_val;
    logic               at_last;
    logic               load_en;

    qfd_word_sel #(.N_W(N_W)) u_sel (
        .word_a     (n_word_a),
        .word_b     (n_word_b),
        .sel_b      (sel_b),
        .shift_en_n (shift_en_n),
        .frac_en_n  (frac_en_n),
        .base       (base),
        .frac       (frac),
        .frac_act   (frac_act)
    );

    qfd_frac_acc u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .frac_act (frac_act),
        .frac     (frac),
        .carry    (carry),
        .acc_q    (acc_q)
    );

    qfd_divisor #(.N_W(N_W), .CNT_W(CNT_W)) u_div (
        .base    (base),
        .carry   (carry),
        .div_val (div_val)
    );

    assign at_last = (state_q == ST_COUNT) && (cnt_q == LAST);
    assign load_en = (state_q == ST_START) || at_last;

    // Next state: launch from START, then stay in COUNT (tick / wrap).
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_START: state_d = ST_COUNT;
            ST_COUNT: state_d = ST_COUNT;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_START;
        end else begin
            state_q <= state_d;
        end
    end

    // Counter and pulse output.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            div_pulse <= 1'b0;
        end else begin
            unique case (state_q)
                ST_START: begin
                    cnt_q     <= div_val;
                    div_pulse <= 1'b0;
                end
                ST_COUNT: begin
                    if (at_last) begin
                        cnt_q     <= div_val;
                        div_pulse <= 1'b1;
                    end else begin
                        cnt_q     <= cnt_q - LAST;
                        div_pulse <= 1'b0;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/qfd_checker.sv
module qfd_checker
    import qfd_pkg::*;
#(
    parameter int N_W = 18
) (
    input logic               clk,
    input logic               rst_n,
    input div_state_t         state_q,
    input logic [N_W:0]       cnt_q,
    input logic               load_en,
    input logic               frac_act,
    input logic [SHIFT_W-1:0] acc_q,
    input logic               div_pulse
);
    // R1: no pulse while the first period is being launched
    p_start_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START) |-> !div_pulse);

    // R3: the counter never idles at zero while counting
    p_cnt_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT) |-> (cnt_q != '0));

    // R8: the pulse is one clock wide
    p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

    // R8: the last count of a period is followed by a pulse
    p_pulse_on_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && cnt_q == 1) |=> div_pulse);

    // R9: every freshly loaded period is at least two clocks
    p_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (cnt_q >= 2));

    // R10: accumulator clears when a period loads without fraction
    p_acc_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && !frac_act) |=> (acc_q == '0));

    // R7: accumulator only moves on a period boundary
    p_acc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(acc_q));
endmodule

bind qfrac_fb_div qfd_checker #(.N_W(N_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .cnt_q     (cnt_q),
    .load_en   (load_en),
    .frac_act  (frac_act),
    .acc_q     (acc_q),
    .div_pulse (div_pulse)
);

// File: tb/qfrac_fb_div_tb_top.sv
module qfrac_fb_div_tb_top;
    localparam int N_W = 18;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N_W-1:0] wa = '0;
    logic [N_W-1:0] wb = '0;
    logic           sel = 1'b0;
    logic           sh_n = 1'b1;
    logic           fr_n = 1'b1;
    logic           div_pulse;

    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_rem = 0;
    int m_acc = 0;
    bit m_started = 1'b0;
    bit m_exp = 1'b0;

    always #5 clk = ~clk;

    qfrac_fb_div #(.N_W(N_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .n_word_a   (wa),
        .n_word_b   (wb),
        .sel_b      (sel),
        .shift_en_n (sh_n),
        .frac_en_n  (fr_n),
        .div_pulse  (div_pulse)
    );

    // Reference model: period length from the requirements, evaluated per clock.
    always @(posedge clk) begin : ref_model
        int n, base, car, s, d;
        if (!rst_n) begin
            m_started = 1'b0;
            m_exp = 1'b0;
            m_acc = 0;
            m_rem = 0;
        end else if (!m_started || m_rem == 1) begin
            n = sel ? int'(wb) : int'(wa);
            car = 0;
            if (!sh_n) begin
                base = n / 4;
                if (!fr_n) begin
                    s = m_acc + (n % 4);
                    car = s / 4;
                    m_acc = s % 4;
                end else begin
                    m_acc = 0;
                end
            end else begin
                base = n;
                m_acc = 0;
            end
            d = base + car;
            if (d < 2) d = 2;
            m_exp = m_started;
            m_started = 1'b1;
            m_rem = d;
        end else begin
            m_rem = m_rem - 1;
            m_exp = 1'b0;
        end
    end

    always @(negedge clk) begin
        checks++;
        if (div_pulse !== m_exp) begin
            fails++;
            $display("FAIL %s per-clock model: actual=%0b expected=%0b", cur_req, div_pulse, m_exp);
        end
    end

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL %s watchdog expired: actual=%0d cycles expected=fewer", cur_req, cyc);
            finish_up();
        end
    end

    task automatic check_eq(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Count clocks from the current pulse to the next one; ends on the pulse.
    task automatic measure(output int len);
        len = 0;
        do begin
            @(negedge clk);
            len++;
            if (len == 1) check_eq("R8", int'(div_pulse), 0, "pulse width one clock");
        end while (!div_pulse);
    endtask

    task automatic expect_q(string req, int e[$]);
        int l;
        cur_req = req;
        foreach (e[i]) begin
            measure(l);
            check_eq(req, l, e[i], "period length");
        end
    endtask

    // Change configuration right after a pulse; the period in flight keeps old_d.
    task automatic apply(int a, int b, bit s, bit sh, bit fr, int old_d);
        int l;
        wa = N_W'(a);
        wb = N_W'(b);
        sel = s;
        sh_n = sh;
        fr_n = fr;
        cur_req = "R7";
        measure(l);
        check_eq("R7", l, old_d, "period in flight unchanged");
    endtask

    initial begin
        int l;
        wa = 10; wb = 23; sel = 0; sh_n = 1; fr_n = 1;
        repeat (4) begin
            @(negedge clk);
            check_eq("R1", int'(div_pulse), 0, "pulse low in reset");
        end
        rst_n = 1'b1;
        measure(l);
        check_eq("R1", l, 11, "first pulse after launch");

        expect_q("R3", '{10, 10, 10});

        apply(10, 23, 1, 1, 1, 10);
        expect_q("R2", '{23, 23});

        // fraction enable without shift
        apply(10, 23, 1, 1, 0, 23);
        expect_q("R6", '{23, 23});

        // shift, no fraction: 103 -> 25
        apply(10, 103, 1, 0, 1, 23);
        expect_q("R4", '{25, 25, 25, 25});

        // fraction 3
        apply(10, 103, 1, 0, 0, 25);
        expect_q("R10", '{25, 26, 26, 26});
        expect_q("R5", '{25, 26, 26, 26});

        // fraction 2
        apply(10, 102, 1, 0, 1, 25);
        expect_q("R4", '{25});
        apply(10, 102, 1, 0, 0, 25);
        expect_q("R10", '{25, 26, 25, 26});

        // fraction 1: 9113 averages 2278.25
        apply(10, 9113, 1, 0, 1, 25);
        expect_q("R4", '{2278});
        apply(10, 9113, 1, 0, 0, 2278);
        expect_q("R5", '{2278, 2278, 2278, 2279});

        // fraction 0
        apply(10, 100, 1, 0, 0, 2278);
        expect_q("R5", '{25, 25, 25});

        // floor of 2
        apply(10, 1, 1, 1, 1, 25);
        expect_q("R9", '{2, 2});
        apply(10, 0, 1, 1, 1, 2);
        expect_q("R9", '{2, 2});
        apply(10, 5, 1, 0, 1, 2);
        expect_q("R9", '{2, 2});
        apply(10, 7, 1, 0, 0, 2);
        expect_q("R9", '{2, 2, 2, 2});
        apply(10, 3, 1, 0, 0, 2);
        expect_q("R9", '{2, 2, 2, 2});

        // back to word A; word B must not matter
        apply(10, 3, 0, 1, 1, 2);
        expect_q("R2", '{10, 10});

        // mid-period change of the active word
        cur_req = "R7";
        l = 0;
        repeat (3) begin
            @(negedge clk);
            l++;
        end
        wa = 15;
        while (!div_pulse) begin
            @(negedge clk);
            l++;
        end
        check_eq("R7", l, 10, "mid-period word change deferred");
        expect_q("R7", '{15, 15});

        finish_up();
    end
endmodule